// File: doc/BRIEF.md
# PWM Duty-Cycle Sensor Classifier

This block watches a slow pulse-width-modulated status line from a fluid sensor (nominally 1 kHz, sampled by a 40 MHz clock, so one period is about 40,000 ticks). It measures how long the line stays high and how long each full period lasts, with rising edges of the line marking period boundaries. When a period closes, the high-time count is sorted into one of four status classes: no bubble, small bubble, bubble, or device fault. The class, the two raw counts and a one-cycle valid strobe are presented to downstream safety logic.

The raw line first passes through a synchronizer. After reset, and after a lost signal, the counts gathered before the first rising edge belong to a partial period and are discarded. A line that stays stuck high or stuck low for too long is reported as a device fault. The class windows touch one another, so every high-time count maps to exactly one class.

The controller has three states. `ST_HUNT` is entered at reset and waits for the first rising edge (transition *align*, to `ST_MEASURE`, no report). In `ST_MEASURE`, a rising edge closes a period and reports it (transition *close*, staying in `ST_MEASURE`). If the period count reaches the timeout limit with no edge, a fault is reported (transition *expire*, to `ST_LOST`). `ST_LOST` waits for the next rising edge, which realigns without a report (transition *recover*, to `ST_MEASURE`).

Top module: `pwm_duty_classifier`

## Requirements
- R1: While reset is asserted and on the cycle after it, `valid_o` is 0. Reset clears `class_o`, `high_o` and `period_o` to 0.
- R2: The first rising edge after reset, and the first rising edge after a timeout report, produce no valid strobe. The partial period before that edge is never classified.
- R3: A valid strobe for a closed period is high in the third clock cycle after the first clock edge that samples `pwm_in` high. That is two synchronizer stages plus one output register.
- R4: At a close report, `high_o` equals the number of cycles `pwm_in` was high in the period and `period_o` equals high plus low cycles. Both counts restart on every rising edge.
- R5: Class codes are 0 = no bubble, 1 = small bubble, 2 = bubble, 3 = device fault. For a high count h: LOW_NONE ≤ h < LOW_SMALL gives 0, LOW_SMALL ≤ h < LOW_BUBBLE gives 1, and LOW_BUBBLE ≤ h < LOW_FAULT gives 2. The defaults are 7920, 8316, 31680 and 35640.
- R6: A high count below LOW_NONE is reported as class 3.
- R7: A high count of LOW_FAULT or more is reported as class 3.
- R8: When the period count reaches TIMEOUT (default 48000) with no rising edge, one strobe reports class 3 with `period_o` = TIMEOUT and `high_o` = the high cycles so far. This holds for a line stuck either low or high.
- R9: `valid_o` is never high on two consecutive cycles, and `high_o`/`period_o` change only together with a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_in | input | 1 | Raw, asynchronous sensor PWM line |
| class_o | output | 2 | Latest status class (R5 encoding) |
| valid_o | output | 1 | One-cycle strobe marking a new report |
| high_o | output | CNT_W | High-time ticks of the reported period |
| period_o | output | CNT_W | Period ticks of the reported period |

## Verification
If the controller is in the wrong state, the fault shows up at the next rising edge of the input. A missing or extra strobe appears there, or a report is missing after a timeout, so the error is visible within one PWM period. If the counters are wrong, the very next report carries bad `high_o`/`period_o` values. Near a window boundary, a single-count error also flips `class_o`. For this reason the tests place high times exactly on both sides of each class threshold and compare all three outputs, as well as the strobe latency, on each report.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    typedef enum logic [1:0] {
        CLS_NONE   = 2'd0,
        CLS_SMALL  = 2'd1,
        CLS_BUBBLE = 2'd2,
        CLS_FAULT  = 2'd3
    } duty_class_e;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_MEASURE = 2'd1,
        ST_LOST    = 2'd2
    } meas_state_e;

endpackage

// File: rtl/pdc_sync.sv
module pdc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic level_o,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= raw_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain_q[STAGES-1];
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/pdc_counter.sv
module pdc_counter #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             level_i,
    input  logic             rise_i,
    output logic [CNT_W-1:0] high_cnt_o,
    output logic [CNT_W-1:0] period_cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] high_q, period_q;
    logic             high_full, period_full;

    assign high_full   = (high_q == CNT_MAX);
    assign period_full = (period_q == CNT_MAX);

    // A rising-edge cycle is the first high cycle of a new period.
    always_ff @(posedge clk) begin
        if (rst) begin
            high_q   <= '0;
            period_q <= '0;
        end else if (rise_i) begin
            high_q   <= CNT_ONE;
            period_q <= CNT_ONE;
        end else begin
            if (!period_full)
                period_q <= period_q + CNT_ONE;
            if (level_i && !high_full)
                high_q <= high_q + CNT_ONE;
        end
    end

    assign high_cnt_o   = high_q;
    assign period_cnt_o = period_q;
endmodule

// File: rtl/pdc_decode.sv
module pdc_decode
    import pdc_pkg::*;
#(
    parameter int CNT_W      = 17,
    parameter int LOW_NONE   = 7920,
    parameter int LOW_SMALL  = 8316,
    parameter int LOW_BUBBLE = 31680,
    parameter int LOW_FAULT  = 35640
) (
    input  logic [CNT_W-1:0] high_i,
    output duty_class_e      class_o
);
    localparam logic [CNT_W-1:0] T_NONE   = CNT_W'(LOW_NONE);
    localparam logic [CNT_W-1:0] T_SMALL  = CNT_W'(LOW_SMALL);
    localparam logic [CNT_W-1:0] T_BUBBLE = CNT_W'(LOW_BUBBLE);
    localparam logic [CNT_W-1:0] T_FAULT  = CNT_W'(LOW_FAULT);

    logic ge_none, ge_small, ge_bubble, ge_fault;

    assign ge_none   = (high_i >= T_NONE);
    assign ge_small  = (high_i >= T_SMALL);
    assign ge_bubble = (high_i >= T_BUBBLE);
    assign ge_fault  = (high_i >= T_FAULT);

    // Windows touch: the comparator results form a thermometer code.
    always_comb begin
        if (!ge_none || ge_fault) class_o = CLS_FAULT;
        else if (ge_bubble)       class_o = CLS_BUBBLE;
        else if (ge_small)        class_o = CLS_SMALL;
        else                      class_o = CLS_NONE;
    end
endmodule

// File: rtl/pwm_duty_classifier.sv
module pwm_duty_classifier
    import pdc_pkg::*;
#(
    parameter int CNT_W       = 17,
    parameter int SYNC_STAGES = 2,
    parameter int LOW_NONE    = 7920,
    parameter int LOW_SMALL   = 8316,
    parameter int LOW_BUBBLE  = 31680,
    parameter int LOW_FAULT   = 35640,
    parameter int TIMEOUT     = 48000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwm_in,
    output logic [1:0]       class_o,
    output logic             valid_o,
    output logic [CNT_W-1:0] high_o,
    output logic [CNT_W-1:0] period_o
);
    localparam logic [CNT_W-1:0] T_LIMIT = CNT_W'(TIMEOUT);

    logic             level, rise;
    logic [CNT_W-1:0] high_cnt, period_cnt;
    duty_class_e      dec_class;
    meas_state_e      state_q, state_d;
    logic             expired;

    pdc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .raw_i   (pwm_in),
        .level_o (level),
        .rise_o  (rise)
    );

    pdc_counter #(.CNT_W(CNT_W)) u_count (
        .clk          (clk),
        .rst          (rst),
        .level_i      (level),
        .rise_i       (rise),
        .high_cnt_o   (high_cnt),
        .period_cnt_o (period_cnt)
    );

    pdc_decode #(
        .CNT_W      (CNT_W),
        .LOW_NONE   (LOW_NONE),
        .LOW_SMALL  (LOW_SMALL),
        .LOW_BUBBLE (LOW_BUBBLE),
        .LOW_FAULT  (LOW_FAULT)
    ) u_dec (
        .high_i  (high_cnt),
        .class_o (dec_class)
    );

    assign expired = (period_cnt >= T_LIMIT) && !rise;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT:    if (rise) state_d = ST_MEASURE;      // align
            ST_MEASURE: if (expired) state_d = ST_LOST;      // expire (close stays)
            ST_LOST:    if (rise) state_d = ST_MEASURE;      // recover
            default:    state_d = ST_HUNT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HUNT;
        else     state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o  <= 1'b0;
            class_o  <= CLS_NONE;
            high_o   <= '0;
            period_o <= '0;
        end else begin
            valid_o <= 1'b0;
            unique case (state_q)
                ST_MEASURE: begin
                    if (rise) begin
                        valid_o  <= 1'b1;
                        class_o  <= dec_class;
                        high_o   <= high_cnt;
                        period_o <= period_cnt;
                    end else if (expired) begin
                        valid_o  <= 1'b1;
                        class_o  <= CLS_FAULT;
                        high_o   <= high_cnt;
                        period_o <= period_cnt;
                    end
                end
                ST_HUNT, ST_LOST: ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pdc_checker.sv
module pdc_checker #(
    parameter int CNT_W      = 17,
    parameter int LOW_NONE   = 7920,
    parameter int LOW_SMALL  = 8316,
    parameter int LOW_BUBBLE = 31680,
    parameter int LOW_FAULT  = 35640,
    parameter int TIMEOUT    = 48000
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       class_o,
    input logic             valid_o,
    input logic [CNT_W-1:0] high_o,
    input logic [CNT_W-1:0] period_o
);
    a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !valid_o);

    a_r9_single_strobe: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    a_r9_counts_hold: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> ($stable(high_o) && $stable(period_o)));

    a_r4_high_in_period: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (high_o <= period_o));

    a_r5_none_window: assert property (@(posedge clk) disable iff (rst)
        (valid_o && high_o >= CNT_W'(LOW_NONE) && high_o < CNT_W'(LOW_SMALL)
         && period_o < CNT_W'(TIMEOUT)) |-> (class_o == 2'd0));

    a_r5_bubble_window: assert property (@(posedge clk) disable iff (rst)
        (valid_o && high_o >= CNT_W'(LOW_BUBBLE) && high_o < CNT_W'(LOW_FAULT)
         && period_o < CNT_W'(TIMEOUT)) |-> (class_o == 2'd2));

    a_r6_short_fault: assert property (@(posedge clk) disable iff (rst)
        (valid_o && high_o < CNT_W'(LOW_NONE)) |-> (class_o == 2'd3));

    a_r7_long_fault: assert property (@(posedge clk) disable iff (rst)
        (valid_o && high_o >= CNT_W'(LOW_FAULT)) |-> (class_o == 2'd3));

    a_r8_timeout_fault: assert property (@(posedge clk) disable iff (rst)
        (valid_o && period_o >= CNT_W'(TIMEOUT)) |-> (class_o == 2'd3));
endmodule

bind pwm_duty_classifier pdc_checker #(
    .CNT_W      (CNT_W),
    .LOW_NONE   (LOW_NONE),
    .LOW_SMALL  (LOW_SMALL),
    .LOW_BUBBLE (LOW_BUBBLE),
    .LOW_FAULT  (LOW_FAULT),
    .TIMEOUT    (TIMEOUT)
) u_pdc_checker (
    .clk      (clk),
    .rst      (rst),
    .class_o  (class_o),
    .valid_o  (valid_o),
    .high_o   (high_o),
    .period_o (period_o)
);

// File: tb/pwm_duty_classifier_bench.sv
module pwm_duty_classifier_bench;
    localparam int CW = 12;
    localparam int T_NONE = 198, T_SMALL = 208, T_BUBBLE = 792, T_FAULT = 891;
    localparam int T_OUT = 1200;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pwm_in = 1'b0;
    logic [1:0]    class_o;
    logic          valid_o;
    logic [CW-1:0] high_o, period_o;

    int n_run = 0, n_fail = 0, hi_spent = 0, vcount = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pwm_duty_classifier #(
        .CNT_W(CW), .SYNC_STAGES(2), .LOW_NONE(T_NONE), .LOW_SMALL(T_SMALL),
        .LOW_BUBBLE(T_BUBBLE), .LOW_FAULT(T_FAULT), .TIMEOUT(T_OUT)
    ) u_pwm_duty_classifier (
        .clk(clk), .rst(rst), .pwm_in(pwm_in), .class_o(class_o),
        .valid_o(valid_o), .high_o(high_o), .period_o(period_o)
    );

    always @(negedge clk) if (valid_o) vcount++;

    task automatic check(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int cls_of(int h);
        if (h < T_NONE || h >= T_FAULT) return 3;
        if (h >= T_BUBBLE) return 2;
        if (h >= T_SMALL) return 1;
        return 0;
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 valid", valid_o, 0);
        check("R1 class", class_o, 0);
        check("R1 high", high_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after release", valid_o, 0);
        repeat (30) @(negedge clk);
    endtask

    // Raise the line and confirm the aligning edge is not reported.
    task automatic t_align(string tag);
        int v0 = vcount;
        pwm_in = 1'b1;
        hi_spent = 0;
        repeat (20) begin @(negedge clk); hi_spent++; end
        check({tag, " aligning edge discarded"}, vcount - v0, 0);
    endtask

    // Complete a period of h high / l low cycles, then open the next.
    task automatic t_period(int h, int l);
        int lat = 0;
        pwm_in = 1'b1;
        for (int i = hi_spent; i < h; i++) @(negedge clk);
        pwm_in = 1'b0;
        repeat (l) @(negedge clk);
        pwm_in = 1'b1;
        hi_spent = 0;
        for (int k = 0; k < 10 && !valid_o; k++) begin
            @(negedge clk); hi_spent++; lat++;
            if (valid_o) break;
        end
        check("R3 strobe latency", lat, 3);
        check("R4 high count", high_o, h);
        check("R4 period count", period_o, h + l);
        if (h < T_NONE)       check("R6 short high class", class_o, 3);
        else if (h >= T_FAULT) check("R7 long high class", class_o, 3);
        else                  check("R5 class", class_o, cls_of(h));
        @(negedge clk); hi_spent++;
        check("R9 strobe one cycle", valid_o, 0);
    endtask

    task automatic t_stuck(bit lvl, int h);
        int waited = 0, v0;
        pwm_in = 1'b1;
        for (int i = hi_spent; i < h; i++) @(negedge clk);
        pwm_in = lvl;
        v0 = vcount;
        while (!valid_o && waited < 2 * T_OUT) begin @(negedge clk); waited++; end
        check("R8 timeout strobe", valid_o, 1);
        check("R8 timeout class", class_o, 3);
        check("R8 timeout period", period_o, T_OUT);
        check("R8 timeout high", high_o, lvl ? T_OUT : h);
        repeat (200) @(negedge clk);
        check("R9 single timeout report", vcount - v0, 1);
        pwm_in = 1'b0;
        repeat (10) @(negedge clk);
        t_align("R2 after timeout");
    endtask

    initial begin
        t_reset();
        t_align("R2 after reset");
        t_period(250, 750);
        t_period(197, 803);
        t_period(198, 802);
        t_period(207, 793);
        t_period(208, 792);
        t_period(500, 500);
        t_period(791, 209);
        t_period(792, 208);
        t_period(890, 110);
        t_period(891, 109);
        t_period(950, 50);
        t_stuck(1'b0, 300);
        t_period(400, 600);
        t_stuck(1'b1, 300);
        t_period(220, 780);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule